// File: doc/BRIEF.md
# Segmented DAC Input Register

This block is the digital front end of a 12-bit segmented current-steering converter. It takes a parallel 12-bit input word and splits it into two groups of switch enables. The upper four bits become fifteen equally weighted segment enables in thermometer form. The lower eight bits pass straight through as binary-weighted enables.

In clocked mode the block is a two-stage register. The first stage is open while the clock is low and closes on the rising edge. The thermometer decoder sits after the first stage and before the second, so the second stage captures the fully decoded segment enables on the rising edge. Decode delay and input skew therefore never show on the outputs.

In bypass mode both stages are transparent, so the input word reaches the outputs through combinational logic only. A rebuilt 12-bit code output is provided for checking; it should always equal the word held in the register.

Top module: `seg_dac_front`

## Requirements
- R1: While `rst_ni` is low, `seg_en_o`, `lsb_en_o` and `code_o` are all zero, and they go to zero as soon as `rst_ni` falls, without waiting for a clock edge.
- R2: With `bypass_i` low, the outputs change only on a rising edge of `clk_i`. After that edge they show the value that `data_i` had just before the edge.
- R3: With `bypass_i` low, changes on `data_i` have no effect on the outputs while `clk_i` is high. Changes while `clk_i` is low have no effect until the next rising edge, and only the last value before that edge counts.
- R4: Bit k of `seg_en_o` (k = 0..14) is 1 exactly when the unsigned value of `data_i[11:8]` that was captured is greater than k. So the enables fill from bit 0 upward, and the number of ones equals that value.
- R5: Bit i of `lsb_en_o` (i = 0..7, weight 2^i) equals bit i of the captured `data_i`, with no decoding.
- R6: With `bypass_i` high, all outputs follow `data_i` combinationally, in either clock phase. When `bypass_i` falls, the outputs show the word captured at the last rising edge.
- R7: `code_o` equals 256 × (number of ones in `seg_en_o`) + `lsb_en_o`, which is the captured input word.
- R8: Moving from code 0x000 to 0xFFF shows no intermediate value: the outputs read zero just before the edge, and all 15 segments plus `lsb_en_o` = 0xFF just after it. Midscale 0x800 gives exactly 8 segments and `lsb_en_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock; capture on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bypass_i | input | 1 | 1 = both stages transparent, 0 = clocked |
| data_i | input | 12 | Input code, bit 11 most significant |
| seg_en_o | output | 15 | Thermometer segment enables from bits 11..8 |
| lsb_en_o | output | 8 | Binary-weighted enables from bits 7..0 |
| code_o | output | 12 | Rebuilt code for checking |

## Verification
The bench changes `data_i` while the clock is high and expects the outputs not to move. A first stage that stayed open in the high phase would leak those values. The bench also makes several changes while the clock is low and expects only the last one to be captured; an edge-sampled design built the wrong way would catch an earlier value.

The zero-to-full-scale step is sampled just before and just after the edge. A design that updated the segments and the low bits at different moments would show a partial code. Bypass is tested in both clock phases and again on exit, which catches designs that still gate the output with the clock or that lose the held word. Reset is asserted between edges to show that clearing does not wait for the clock.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int unsigned SDAC_MSB_W = 4;
  localparam int unsigned SDAC_LSB_W = 8;
endpackage

// File: rtl/sdac_master_stage.sv
module sdac_master_stage #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         open_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // level latch: open in the low phase or whenever bypass forces it open
  always_latch begin
    if (!rst_ni)               q_o <= '0;
    else if (!clk_i || open_i) q_o <= d_i;
  end
endmodule

// File: rtl/sdac_therm_decode.sv
module sdac_therm_decode #(
  parameter int IN_W  = 4,
  parameter int OUT_W = 15
) (
  input  logic [IN_W-1:0]  bin_i,
  output logic [OUT_W-1:0] therm_o
);
  for (genvar k = 0; k < OUT_W; k++) begin : g_seg
    assign therm_o[k] = (int'(bin_i) > k);
  end
endmodule

// File: rtl/sdac_slave_stage.sv
module sdac_slave_stage #(
  parameter int W = 23
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bypass_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else         hold_q <= d_i;
  end

  assign q_o = bypass_i ? d_i : hold_q;
endmodule

// File: rtl/sdac_code_rebuild.sv
module sdac_code_rebuild #(
  parameter int MSB_W = 4,
  parameter int LSB_W = 8,
  parameter int SEG_N = 15
) (
  input  logic [SEG_N-1:0]       seg_i,
  input  logic [LSB_W-1:0]       lsb_i,
  output logic [MSB_W+LSB_W-1:0] code_o
);
  logic [MSB_W-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int k = 0; k < SEG_N; k++) cnt = cnt + MSB_W'(seg_i[k]);
  end

  assign code_o = {cnt, lsb_i};
endmodule

// File: rtl/seg_dac_front.sv
module seg_dac_front #(
  parameter int MSB_W = sdac_pkg::SDAC_MSB_W,
  parameter int LSB_W = sdac_pkg::SDAC_LSB_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bypass_i,
  input  logic [MSB_W+LSB_W-1:0]    data_i,
  output logic [(1<<MSB_W)-2:0]     seg_en_o,
  output logic [LSB_W-1:0]          lsb_en_o,
  output logic [MSB_W+LSB_W-1:0]    code_o
);
  localparam int DATA_W  = MSB_W + LSB_W;
  localparam int SEG_N   = (1 << MSB_W) - 1;
  localparam int STAGE_W = SEG_N + LSB_W;

  logic [DATA_W-1:0]  mst_q;
  logic [SEG_N-1:0]   seg_dec;
  logic [STAGE_W-1:0] slv_d, slv_q;

  sdac_master_stage #(.W(DATA_W)) u_mst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .open_i (bypass_i),
    .d_i    (data_i),
    .q_o    (mst_q)
  );

  // decode between stages so its settling never reaches the outputs
  sdac_therm_decode #(.IN_W(MSB_W), .OUT_W(SEG_N)) u_dec (
    .bin_i   (mst_q[DATA_W-1:LSB_W]),
    .therm_o (seg_dec)
  );

  assign slv_d = {seg_dec, mst_q[LSB_W-1:0]};

  sdac_slave_stage #(.W(STAGE_W)) u_slv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bypass_i (bypass_i),
    .d_i      (slv_d),
    .q_o      (slv_q)
  );

  assign seg_en_o = slv_q[STAGE_W-1:LSB_W];
  assign lsb_en_o = slv_q[LSB_W-1:0];

  sdac_code_rebuild #(.MSB_W(MSB_W), .LSB_W(LSB_W), .SEG_N(SEG_N)) u_rebuild (
    .seg_i  (seg_en_o),
    .lsb_i  (lsb_en_o),
    .code_o (code_o)
  );
endmodule

// File: rtl/seg_dac_front_chk.sv
module seg_dac_front_chk #(
  parameter int MSB_W = 4,
  parameter int LSB_W = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   bypass_i,
  input logic [MSB_W+LSB_W-1:0] data_i,
  input logic [(1<<MSB_W)-2:0]  seg_en_o,
  input logic [LSB_W-1:0]       lsb_en_o,
  input logic [MSB_W+LSB_W-1:0] code_o
);
  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (seg_en_o == '0 && lsb_en_o == '0 && code_o == '0));

  a_r2_edge_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bypass_i |=> (bypass_i || code_o == $past(data_i)));

  a_r5_lsb_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bypass_i |=> (bypass_i || lsb_en_o == $past(data_i[LSB_W-1:0])));

  a_r4_therm_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_en_o & (seg_en_o + 1'b1)) == '0);

  a_r6_bypass_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |-> code_o == data_i);
endmodule

bind seg_dac_front seg_dac_front_chk #(.MSB_W(MSB_W), .LSB_W(LSB_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bypass_i (bypass_i),
  .data_i   (data_i),
  .seg_en_o (seg_en_o),
  .lsb_en_o (lsb_en_o),
  .code_o   (code_o)
);

// File: tb/seg_dac_front_tb_top.sv
`timescale 1ns/1ps
module seg_dac_front_tb_top;
  localparam int N_VEC = 8;
  localparam logic [11:0] VEC [N_VEC] = '{12'h000, 12'h001, 12'h7FF, 12'h800,
                                          12'hFFF, 12'h0A5, 12'hF00, 12'h3C3};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bypass = 1'b0;
  logic [11:0] data = 12'hABC;
  logic [14:0] seg_en;
  logic [7:0]  lsb_en;
  logic [11:0] code;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seg_dac_front dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .bypass_i (bypass),
    .data_i   (data),
    .seg_en_o (seg_en),
    .lsb_en_o (lsb_en),
    .code_o   (code)
  );

  function automatic logic [14:0] therm_of(logic [3:0] v);
    logic [14:0] r;
    for (int k = 0; k < 15; k++) r[k] = (v > k);
    return r;
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic expect_word(string req, logic [11:0] w);
    chk(req, "seg_en", 32'(seg_en), 32'(therm_of(w[11:8])));
    chk(req, "lsb_en", 32'(lsb_en), 32'(w[7:0]));
    chk(req, "code",   32'(code),   32'(w));
  endtask

  initial begin
    #1;
    expect_word("R1 reset", 12'h000);
    @(posedge clk); #1;
    expect_word("R1 reset edge", 12'h000);
    @(negedge clk); #1 rst_n = 1'b1;

    // vector table: R2/R4/R5/R7
    for (int i = 0; i < N_VEC; i++) begin
      @(negedge clk); #1 data = VEC[i];
      @(posedge clk); #1;
      expect_word("R2/R4/R5/R7 vec", VEC[i]);
    end

    // R3: high-phase changes ignored, only last low-phase value captured
    @(negedge clk); #1 data = 12'h123;
    @(posedge clk); #1;
    expect_word("R3 base", 12'h123);
    data = 12'hEDC; #0.5;
    expect_word("R3 high phase", 12'h123);
    @(negedge clk); #1;
    expect_word("R3 low phase", 12'h123);
    @(posedge clk); #1;
    expect_word("R3 next edge", 12'hEDC);
    data = 12'h456;
    @(negedge clk); #0.5 data = 12'h789; #0.5 data = 12'h24B;
    @(posedge clk); #1;
    expect_word("R3 last low value", 12'h24B);

    // R8 full-scale step and midscale
    @(negedge clk); #1 data = 12'h000;
    @(posedge clk); #1;
    expect_word("R8 zero", 12'h000);
    @(negedge clk); #1 data = 12'hFFF; #0.5;
    expect_word("R8 before edge", 12'h000);
    @(posedge clk); #0.1;
    expect_word("R8 after edge", 12'hFFF);
    @(negedge clk); #1 data = 12'h800;
    @(posedge clk); #1;
    chk("R8 midscale", "seg count", 32'($countones(seg_en)), 32'd8);
    chk("R8 midscale", "lsb_en", 32'(lsb_en), 32'd0);

    // R6 bypass in both phases, then exit
    @(negedge clk); #1 bypass = 1'b1; #0.2;
    expect_word("R6 enter", 12'h800);
    data = 12'h5A3; #0.2;
    expect_word("R6 low phase", 12'h5A3);
    @(posedge clk); #1 data = 12'h1FF; #0.2;
    expect_word("R6 high phase", 12'h1FF);
    data = 12'hE01; #0.2;
    expect_word("R6 high phase 2", 12'hE01);
    @(posedge clk); @(negedge clk); #1 bypass = 1'b0; #0.2;
    expect_word("R6 exit holds", 12'hE01);

    // R1 asynchronous reset mid-cycle
    @(negedge clk); #1 rst_n = 1'b0; #0.2;
    expect_word("R1 async", 12'h000);
    @(posedge clk); #1;
    expect_word("R1 held", 12'h000);
    @(negedge clk); #1 rst_n = 1'b1; data = 12'h9C6;
    @(posedge clk); #1;
    expect_word("R2 after reset", 12'h9C6);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule